// File: doc/BRIEF.md
# SATA Port Command-Slot Status Registers

This block is the per-port status register set of a SATA host controller. It records which command slots software has issued and which native-queued (FPDMA) slots are still outstanding at the device. It keeps one notification flag per port-multiplier number and latches six classes of link and host-bus error. Software reads and writes it through a plain 32-bit register port addressed by word offset. The link layer reports the hardware events that clear or set bits:
- D2H Register FIS status bits
- Set Device Bits FIS arrival, with its completion bitmap, port-multiplier number and notify bit
- error strobes
- COMRESET

Each register has its own ownership rule. Command-issue and SActive bits are set only by software and cleared only by hardware. Notification and error bits are set only by hardware and cleared by software writing ones. Notification flags survive a COMRESET. Whenever a hardware set and a software clear of the same bit meet in one cycle, the set is kept, so no event is lost. A 4-bit select field in the notification register names the port multiplier that a neighbouring command-issue-clear action targets; its value is also driven out of the block.

Top module: `sata_port_slot_regs`

## Requirements
- R1: Writing the command-issue register (word offset 2) sets each bit written as 1. Bits written as 0 are left unchanged, and no software write can clear a bit.
- R2: A D2H status event with BSY, DRQ and ERR all 0 clears the command-issue bit of the slot number it carries; any other status combination changes nothing. A software set in the same cycle is also applied, and it wins if it names the same slot.
- R3: Writing the SActive register (word offset 1) sets each bit written as 1; a software write never clears an SActive bit.
- R4: A Set Device Bits event clears every SActive bit that is 1 in its completion bitmap. A software set of the same bit in the same cycle wins.
- R5: The notification register (word offset 3) holds bits 15:0, one per port-multiplier number. A Set Device Bits event with the notify bit at 1 sets the bit of its port-multiplier number; with notify at 0 it sets none. Writing 1 to a bit clears it, and a set in the same cycle wins.
- R6: COMRESET clears the command-issue and SActive registers (over any software set in that cycle) and leaves the notification bits unchanged.
- R7: Notification register bits 27:24 are a read/write select field, also driven on `cmd_clr_pm`. Bits 31:28 and 23:16 read as 0, and writes to them are ignored.
- R8: The error register (word offset 0) latches one bit per error strobe. Bit 0 is the host-bus master/target abort, bit 1 a protocol violation, bit 2 a persistent communication error, bit 3 an unrecovered data-integrity error, bit 4 a recovered communication error, and bit 5 a recovered data-integrity error. Writing 1 clears a bit, a strobe in the same cycle wins, and bits 31:6 read as 0.
- R9: A read returns the addressed register on `reg_rdata` one cycle after `reg_rd` is high; `reg_rdata` is 0 in cycles that follow no read. After system reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| reg_addr | input | 2 | Register word offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| d2h_valid | input | 1 | D2H Register FIS status received |
| d2h_slot | input | 5 | Command slot the status belongs to |
| d2h_bsy | input | 1 | Received BSY bit |
| d2h_drq | input | 1 | Received DRQ bit |
| d2h_err | input | 1 | Received ERR bit |
| sdb_valid | input | 1 | Set Device Bits FIS received |
| sdb_done | input | 32 | Completed-slot bitmap of that FIS |
| sdb_pm | input | 4 | Port-multiplier number of that FIS |
| sdb_notify | input | 1 | Notify bit of that FIS |
| err_evt | input | 6 | Error strobes, one per error class |
| comreset | input | 1 | COMRESET issued on the link |
| cmd_clr_pm | output | 4 | Selected port multiplier for the command-issue-clear action |

## Verification
A wrong internal state here shows up only through a register read. A lost hardware clear leaves a slot bit at 1, and a dropped event leaves a notification or error bit at 0. A leaked software clear removes a bit that should have stayed. Each of these is visible on `reg_rdata` exactly one cycle after the next read of that offset, so the bench reads the affected register right after every stimulus. The same-cycle collisions between set and clear, and COMRESET against notification state, are driven on purpose, because a wrong priority would otherwise stay hidden.

// File: rtl/sata_slot_pkg.sv
package sata_slot_pkg;
  typedef enum logic [1:0] {
    OFS_ERR   = 2'd0,
    OFS_SACT  = 2'd1,
    OFS_CI    = 2'd2,
    OFS_NOTIF = 2'd3
  } reg_ofs_e;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SEL_LSB   = 24;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned ERR_ABORT = 0;
  localparam int unsigned ERR_PROTO = 1;
  localparam int unsigned ERR_PCOMM = 2;
  localparam int unsigned ERR_TDATA = 3;
  localparam int unsigned ERR_RCOMM = 4;
  localparam int unsigned ERR_RDATA = 5;
  localparam int unsigned ERR_NUM   = 6;
endpackage

// File: rtl/slot_rst_sync.sv
module slot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/slot_track.sv
module slot_track #(
  parameter int unsigned SLOTS = 32,
  localparam int unsigned SLOT_IW = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               wr_ci,
  input  logic               wr_sact,
  input  logic [SLOTS-1:0]   wdata,
  input  logic               d2h_valid,
  input  logic [SLOT_IW-1:0] d2h_slot,
  input  logic               d2h_bsy,
  input  logic               d2h_drq,
  input  logic               d2h_err,
  input  logic               sdb_valid,
  input  logic [SLOTS-1:0]   sdb_done,
  input  logic               comreset,
  output logic [SLOTS-1:0]   ci,
  output logic [SLOTS-1:0]   sact
);
  logic             d2h_idle;
  logic [SLOTS-1:0] ci_clr, ci_set, sa_clr, sa_set;
  logic [SLOTS-1:0] ci_nxt, sa_nxt;
  logic             ci_en, sa_en;

  always_comb begin
    d2h_idle = d2h_valid && !d2h_bsy && !d2h_drq && !d2h_err;
    ci_clr   = d2h_idle ? (SLOTS'(1) << d2h_slot) : '0;
    ci_set   = wr_ci ? wdata : '0;
    sa_clr   = sdb_valid ? sdb_done : '0;
    sa_set   = wr_sact ? wdata : '0;
    ci_en    = comreset || d2h_idle || wr_ci;
    sa_en    = comreset || sdb_valid || wr_sact;
    if (comreset) begin
      ci_nxt = '0;
      sa_nxt = '0;
    end else begin
      ci_nxt = (ci & ~ci_clr) | ci_set;
      sa_nxt = (sact & ~sa_clr) | sa_set;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ci   <= '0;
      sact <= '0;
    end else begin
      if (ci_en) ci   <= ci_nxt;
      if (sa_en) sact <= sa_nxt;
    end
  end

  // R1
  ci_no_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!comreset && !d2h_valid) |=> (($past(ci) & ~ci) == '0));

  // R2
  ci_hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (d2h_valid && !d2h_bsy && !d2h_drq && !d2h_err && !comreset &&
     !(wr_ci && wdata[d2h_slot])) |=> !ci[$past(d2h_slot)]);

  // R3
  sact_no_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!comreset && !sdb_valid) |=> (($past(sact) & ~sact) == '0));

  // R4
  sact_sdb_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sdb_valid && !comreset && !wr_sact) |=> ((sact & $past(sdb_done)) == '0));

  // R6
  comreset_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    comreset |=> (ci == '0 && sact == '0));
endmodule

// File: rtl/pm_notify.sv
module pm_notify #(
  parameter int unsigned PM_N  = 16,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             wr_notif,
  input  logic [PM_N-1:0]  wclr,
  input  logic [SEL_W-1:0] wsel,
  input  logic             sdb_valid,
  input  logic [SEL_W-1:0] sdb_pm,
  input  logic             sdb_notify,
  input  logic             comreset,
  output logic [PM_N-1:0]  notif,
  output logic [SEL_W-1:0] sel
);
  logic [PM_N-1:0] hit;

  always_comb begin
    hit = '0;
    if (sdb_valid && sdb_notify) hit = PM_N'(1) << sdb_pm;
  end

  for (genvar p = 0; p < PM_N; p++) begin : g_pm
    logic bit_nxt, bit_en;
    always_comb begin
      bit_en  = hit[p] || (wr_notif && wclr[p]);
      bit_nxt = hit[p];
    end
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)     notif[p] <= 1'b0;
      else if (bit_en) notif[p] <= bit_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)       sel <= '0;
    else if (wr_notif) sel <= wsel;
  end

  // R6
  notif_survive_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (comreset && !sdb_valid && !wr_notif) |=> $stable(notif));

  // R5
  notif_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sdb_valid && sdb_notify) |=> notif[$past(sdb_pm)]);
endmodule

// File: rtl/err_latch.sv
module err_latch #(
  parameter int unsigned ERR_N = 6
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             wr_err,
  input  logic [ERR_N-1:0] wclr,
  input  logic [ERR_N-1:0] err_evt,
  output logic [ERR_N-1:0] err
);
  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    logic bit_en;
    always_comb bit_en = err_evt[i] || (wr_err && wclr[i]);
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)     err[i] <= 1'b0;
      else if (bit_en) err[i] <= err_evt[i];
    end
  end

  // R8
  err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (err_evt != '0) |=> ((err & $past(err_evt)) == $past(err_evt)));

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!wr_err) |=> (($past(err) & ~err) == '0));
endmodule

// File: rtl/sata_port_slot_regs.sv
module sata_port_slot_regs
  import sata_slot_pkg::*;
#(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned PM_N  = 16,
  localparam int unsigned SLOT_IW = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  input  logic               reg_rd,
  output logic [31:0]        reg_rdata,
  input  logic               d2h_valid,
  input  logic [SLOT_IW-1:0] d2h_slot,
  input  logic               d2h_bsy,
  input  logic               d2h_drq,
  input  logic               d2h_err,
  input  logic               sdb_valid,
  input  logic [SLOTS-1:0]   sdb_done,
  input  logic [3:0]         sdb_pm,
  input  logic               sdb_notify,
  input  logic [5:0]         err_evt,
  input  logic               comreset,
  output logic [3:0]         cmd_clr_pm
);
  logic              rst_sn;
  logic              wr_err, wr_sact, wr_ci, wr_notif;
  logic [SLOTS-1:0]  ci, sact;
  logic [PM_N-1:0]   notif;
  logic [ERR_NUM-1:0] err;
  logic [SEL_W-1:0]  sel;
  logic [WORD_W-1:0] rd_word, rdata_nxt;
  logic              rd_q;
  logic [1:0]        addr_q;

  slot_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  always_comb begin
    wr_err   = reg_wr && (reg_addr == OFS_ERR);
    wr_sact  = reg_wr && (reg_addr == OFS_SACT);
    wr_ci    = reg_wr && (reg_addr == OFS_CI);
    wr_notif = reg_wr && (reg_addr == OFS_NOTIF);
  end

  slot_track #(.SLOTS(SLOTS)) u_slots (
    .clk(clk), .rst_sn(rst_sn),
    .wr_ci(wr_ci), .wr_sact(wr_sact), .wdata(reg_wdata[SLOTS-1:0]),
    .d2h_valid(d2h_valid), .d2h_slot(d2h_slot),
    .d2h_bsy(d2h_bsy), .d2h_drq(d2h_drq), .d2h_err(d2h_err),
    .sdb_valid(sdb_valid), .sdb_done(sdb_done), .comreset(comreset),
    .ci(ci), .sact(sact)
  );

  pm_notify #(.PM_N(PM_N), .SEL_W(SEL_W)) u_notif (
    .clk(clk), .rst_sn(rst_sn),
    .wr_notif(wr_notif), .wclr(reg_wdata[PM_N-1:0]),
    .wsel(reg_wdata[SEL_LSB +: SEL_W]),
    .sdb_valid(sdb_valid), .sdb_pm(sdb_pm), .sdb_notify(sdb_notify),
    .comreset(comreset), .notif(notif), .sel(sel)
  );

  err_latch #(.ERR_N(ERR_NUM)) u_err (
    .clk(clk), .rst_sn(rst_sn),
    .wr_err(wr_err), .wclr(reg_wdata[ERR_NUM-1:0]),
    .err_evt(err_evt), .err(err)
  );

  always_comb begin
    rd_word = '0;
    unique case (reg_addr)
      OFS_ERR:   rd_word[ERR_NUM-1:0] = err;
      OFS_SACT:  rd_word[SLOTS-1:0]   = sact;
      OFS_CI:    rd_word[SLOTS-1:0]   = ci;
      default: begin
        rd_word[PM_N-1:0]           = notif;
        rd_word[SEL_LSB +: SEL_W]   = sel;
      end
    endcase
    rdata_nxt = reg_rd ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      reg_rdata <= '0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
    end else begin
      reg_rdata <= rdata_nxt;
      rd_q      <= reg_rd;
      addr_q    <= reg_addr;
    end
  end

  assign cmd_clr_pm = sel;

  // R7
  notif_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_q && addr_q == OFS_NOTIF) |-> (reg_rdata[31:28] == '0 && reg_rdata[23:16] == '0));

  // R8
  err_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_q && addr_q == OFS_ERR) |-> (reg_rdata[31:ERR_NUM] == '0));

  // R9
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_q |-> (reg_rdata == '0));
endmodule

// File: tb/sata_port_slot_regs_test.sv
module sata_port_slot_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;
  logic        d2h_valid, d2h_bsy, d2h_drq, d2h_err;
  logic [4:0]  d2h_slot;
  logic        sdb_valid, sdb_notify;
  logic [31:0] sdb_done;
  logic [3:0]  sdb_pm, cmd_clr_pm;
  logic [5:0]  err_evt;
  logic        comreset;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] e_ci, e_sa, e_nt, e_er;
  logic [3:0]  e_sel;
  logic [31:0] got;

  always #5 clk = ~clk;

  sata_port_slot_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .d2h_valid(d2h_valid), .d2h_slot(d2h_slot), .d2h_bsy(d2h_bsy),
    .d2h_drq(d2h_drq), .d2h_err(d2h_err), .sdb_valid(sdb_valid),
    .sdb_done(sdb_done), .sdb_pm(sdb_pm), .sdb_notify(sdb_notify),
    .err_evt(err_evt), .comreset(comreset), .cmd_clr_pm(cmd_clr_pm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    d2h_valid = 0; d2h_slot = 0; d2h_bsy = 0; d2h_drq = 0; d2h_err = 0;
    sdb_valid = 0; sdb_done = 0; sdb_pm = 0; sdb_notify = 0;
    err_evt = 0; comreset = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle_all();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
    idle_all();
  endtask

  task automatic rchk(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  function automatic logic [31:0] nt_word();
    return {4'h0, e_sel, 8'h00, e_nt[15:0]};
  endfunction

  initial begin
    int cyc_n = 0;
    while (!done) begin
      @(posedge clk);
      cyc_n++;
      if (cyc_n > 150000) begin
        n_fail++; n_run++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc_n);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    idle_all();
    rst_n = 0;
    e_ci = 0; e_sa = 0; e_nt = 0; e_er = 0; e_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9 reset values and offsets
    rchk("R9 reset err", 2'd0, 0);
    rchk("R9 reset sact", 2'd1, 0);
    rchk("R9 reset ci", 2'd2, 0);
    rchk("R9 reset notif", 2'd3, 0);
    chk("R7 reset sel", {28'h0, cmd_clr_pm}, 0);
    reg_rd = 1; reg_addr = 2'd2; @(negedge clk); idle_all();
    @(negedge clk);
    chk("R9 no-read rdata zero", reg_rdata, 0);

    // R1 set sweep and zero write
    for (int s = 0; s < 32; s++) begin
      wr(2'd2, 32'h1 << s);
      e_ci |= 32'h1 << s;
      rchk("R1 ci set", 2'd2, e_ci);
    end
    wr(2'd2, 32'h0);
    rchk("R1 ci write 0 no clear", 2'd2, e_ci);

    // R2 status sweep: only BSY=DRQ=ERR=0 clears
    for (int s = 0; s < 32; s++) begin
      for (int c = 7; c >= 0; c--) begin
        d2h_valid = 1; d2h_slot = 5'(s);
        {d2h_bsy, d2h_drq, d2h_err} = 3'(c);
        cyc();
        if (c == 0) e_ci &= ~(32'h1 << s);
        rchk("R2 d2h status", 2'd2, e_ci);
      end
    end
    // R2 concurrent clear + set of another slot, and same slot
    wr(2'd2, 32'h0000_00F0); e_ci |= 32'h0000_00F0;
    d2h_valid = 1; d2h_slot = 5'd4; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h200;
    cyc(); e_ci = (e_ci & ~32'h10) | 32'h200;
    rchk("R2 clear+set other", 2'd2, e_ci);
    d2h_valid = 1; d2h_slot = 5'd5; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h20;
    cyc();
    rchk("R2 same slot set wins", 2'd2, e_ci);

    // R3 SActive
    wr(2'd1, 32'hA5A5_0F0F); e_sa = 32'hA5A5_0F0F;
    rchk("R3 sact set", 2'd1, e_sa);
    wr(2'd1, 32'h0);
    rchk("R3 sact write 0 no clear", 2'd1, e_sa);
    wr(2'd1, 32'hFFFF_FFFF); e_sa = 32'hFFFF_FFFF;
    rchk("R3 sact set all", 2'd1, e_sa);
    // R4 SDB bitmap clear sweep
    for (int s = 0; s < 32; s += 3) begin
      sdb_valid = 1; sdb_done = 32'h1 << s;
      cyc(); e_sa &= ~(32'h1 << s);
      rchk("R4 sdb clear", 2'd1, e_sa);
    end
    sdb_valid = 1; sdb_done = 32'h0000_FFFF; reg_wr = 1; reg_addr = 2'd1; reg_wdata = 32'h2;
    cyc(); e_sa = (e_sa & ~32'h0000_FFFF) | 32'h2;
    rchk("R4 sdb clear vs set wins", 2'd1, e_sa);

    // R5 notification sweep
    for (int p = 0; p < 16; p++) begin
      sdb_valid = 1; sdb_pm = 4'(p); sdb_notify = 0;
      cyc();
      rchk("R5 notify=0 no set", 2'd3, nt_word());
      sdb_valid = 1; sdb_pm = 4'(p); sdb_notify = 1;
      cyc(); e_nt |= 32'h1 << p;
      rchk("R5 notify set", 2'd3, nt_word());
    end

    // R6 COMRESET
    comreset = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h8000_0000;
    cyc(); e_ci = 0; e_sa = 0;
    rchk("R6 ci cleared", 2'd2, 0);
    rchk("R6 sact cleared", 2'd1, 0);
    rchk("R6 notif kept", 2'd3, nt_word());

    // R5 write-1-to-clear and collision
    wr(2'd3, 32'h0000_00FF); e_nt &= ~32'hFF;
    rchk("R5 w1c", 2'd3, nt_word());
    sdb_valid = 1; sdb_pm = 4'd9; sdb_notify = 1; reg_wr = 1; reg_addr = 2'd3; reg_wdata = 32'h0000_0300;
    cyc(); e_nt &= ~32'h100;
    rchk("R5 set wins over clear", 2'd3, nt_word());

    // R7 select field sweep with reserved ones
    for (int v = 0; v < 16; v++) begin
      wr(2'd3, (32'(v) << 24) | 32'hF0FF_0000); e_sel = 4'(v);
      rchk("R7 sel readback", 2'd3, nt_word());
      chk("R7 cmd_clr_pm", {28'h0, cmd_clr_pm}, 32'(v));
    end

    // R8 error bits
    for (int i = 0; i < 6; i++) begin
      err_evt = 6'(1 << i);
      cyc(); e_er |= 32'h1 << i;
      rchk("R8 err set", 2'd0, e_er);
    end
    wr(2'd0, 32'hFFFF_FFC5); e_er &= ~32'h05;
    rchk("R8 w1c partial", 2'd0, e_er);
    err_evt = 6'h04; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'hFFFF_FFFF;
    cyc(); e_er = 32'h04;
    rchk("R8 set wins, upper zero", 2'd0, e_er);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule